// File: doc/BRIEF.md
# Write-Limited Wiper Store Sequencer

This block sequences a small write-limited memory that keeps the setting of a 1024-step digital resistor across power cycles. A store request copies the present wiper code into the next free slot of a 50-entry append-only array, after a long programming delay during which the block reports busy and refuses further work. The block keeps the address of the newest programmed slot and a flag telling whether the last store attempt succeeded.

Any location can be read by a 6-bit address. Two fixed addresses above the slot range return factory resistance-tolerance words that are set by parameters. On reset, and again on each refresh request, the restore output first presents midscale and then the content of the newest programmed slot, if any.

The slot array is modelled as registers that are cleared by reset, so a reset stands for a part whose memory is still blank. The programming delay is a parameter counted in clock cycles.

Top module: `nvm_store_seq`

## Requirements
- R1: After reset, busy and success are 0, last_addr is 0, rd_data is 0 and restore_val is midscale (2^(DATA_W-1), 512 for 10 bits).
- R2: A store request made while not busy, with prog_en at 1 and fewer than NUM_SLOTS slots used, raises busy on the next cycle, and busy then stays high for exactly PROG_CYCLES cycles.
- R3: When an accepted store completes, the wiper_in value sampled with the request is written to address last_addr+1, and last_addr then increments by one. The first store goes to address 1 and the 50th store goes to address 50.
- R4: Every store request made while not busy clears success on the next cycle. success goes to 1 in the same cycle that busy falls after an accepted store.
- R5: A store request with prog_en at 0 is refused: busy stays 0, last_addr is unchanged and success is 0.
- R6: A store request when last_addr equals NUM_SLOTS is refused: busy stays 0, success is 0 and no slot changes.
- R7: While busy is high, store and restore requests are ignored. Only the pending store completes, and restore_val keeps its value.
- R8: A read request loads rd_data, on the next cycle, with the content of the addressed slot. Address 0, addresses of unprogrammed slots and all other unused addresses return 0.
- R9: Address 0x39 returns the tolerance sign in bit 7 (1 = positive) and the integer part in bits 6..0. Address 0x3A returns the fraction in bits 7..0, weighted 2^-1 down to 2^-8. The bits above these read as 0.
- R10: A restore request made while not busy sets restore_val to midscale on the next cycle. On the cycle after that, restore_val takes the content of slot last_addr when last_addr is not 0, and otherwise stays at midscale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (models blank power-up) |
| wiper_in | input | DATA_W | Present wiper code, sampled by a store request |
| prog_en | input | 1 | Store enable; stores are refused while 0 |
| store_req | input | 1 | One-cycle request to store wiper_in |
| restore_req | input | 1 | One-cycle request to refresh restore_val |
| rd_req | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read result, registered |
| last_addr | output | ADDR_W | Address of newest programmed slot, 0 if none |
| busy | output | 1 | Programming in progress |
| success | output | 1 | Last store attempt completed |
| restore_val | output | DATA_W | Wiper value to apply after reset or restore |

## Verification
The assertions take it for granted that requests are single-cycle pulses sampled on the rising edge and that rst_n is low from time zero until a few edges have passed. The busy-window check also relies on store_req not being asserted in the same cycle in which busy falls. The bench drives every request for exactly one cycle, from the falling edge. It waits for busy to drop before it issues the next store, so a request lands in a busy window only in the directed test that targets that window. Restore and store requests are never issued in the same cycle.

// File: rtl/nvm_store_pkg.sv
// Package: shared defaults and helpers for the wiper store sequencer.
// Assumes nothing beyond DATA_W >= 10 so the tolerance words fit.
package nvm_store_pkg;
    localparam int unsigned DEF_DATA_W      = 10;
    localparam int unsigned DEF_ADDR_W      = 6;
    localparam int unsigned DEF_NUM_SLOTS   = 50;
    localparam int unsigned DEF_PROG_CYCLES = 4096;
    localparam logic [5:0]  TOL_HI_ADDR     = 6'h39;
    localparam logic [5:0]  TOL_LO_ADDR     = 6'h3A;

    // Read source chosen by the read decoder.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SLOT = 2'd1,
        SRC_TOLH = 2'd2,
        SRC_TOLL = 2'd3
    } rd_src_e;
endpackage

// File: rtl/nvm_prog_timer.sv
// Module: programming-delay timer.
// Starts on a start pulse and runs for PROG_CYCLES cycles.
// done is high in the last running cycle. Assumes start only while idle.
module nvm_prog_timer #(
    parameter int unsigned PROG_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = running && (cnt_q == LAST);

    // Track the running window and count elapsed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= '0;
        end else if (done) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (running) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nvm_slot_array.sv
// Module: append-only slot storage, addresses 1..NUM_SLOTS.
// Two combinational read ports. Out-of-range reads give 0.
// Assumes the reset models a blank (all-zero) memory.
module nvm_slot_array #(
    parameter int unsigned DATA_W    = 10,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned NUM_SLOTS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] slot_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Store one slot when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && (waddr == ADDR_W'(g + 1)))
                slot_q[g] <= wdata;
        end
    end

    // Select the addressed slot on both read ports.
    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (raddr_a == ADDR_W'(i + 1)) rdata_a = slot_q[i];
            if (raddr_b == ADDR_W'(i + 1)) rdata_b = slot_q[i];
        end
    end
endmodule

// File: rtl/nvm_restore.sv
// Module: restore sequencer.
// On reset or trigger it presents midscale, then on the next cycle
// the newest slot if one exists. Assumes trigger is gated by the caller.
module nvm_restore #(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic              have_slot,
    input  logic [DATA_W-1:0] slot_val,
    output logic [DATA_W-1:0] restore_val
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    logic pending_q;

    // Two-step load: midscale first, then the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore_val <= MID;
            pending_q   <= 1'b1;
        end else if (trigger) begin
            restore_val <= MID;
            pending_q   <= 1'b1;
        end else if (pending_q) begin
            pending_q <= 1'b0;
            if (have_slot) restore_val <= slot_val;
        end
    end
endmodule

// File: rtl/nvm_store_seq.sv
// Module: write-limited wiper store sequencer (top).
// Accepts stores into the next free slot after a fixed delay and tracks
// the newest address and a success flag. Serves indexed reads, including
// two tolerance words, and drives the restore value.
// Assumes requests are one-cycle pulses.
module nvm_store_seq
    import nvm_store_pkg::*;
#(
    parameter int unsigned DATA_W       = DEF_DATA_W,
    parameter int unsigned ADDR_W       = DEF_ADDR_W,
    parameter int unsigned NUM_SLOTS    = DEF_NUM_SLOTS,
    parameter int unsigned PROG_CYCLES  = DEF_PROG_CYCLES,
    parameter logic        TOL_POSITIVE = 1'b0,
    parameter logic [6:0]  TOL_INT      = 7'd10,
    parameter logic [7:0]  TOL_FRAC     = 8'hB0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wiper_in,
    input  logic              prog_en,
    input  logic              store_req,
    input  logic              restore_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] last_addr,
    output logic              busy,
    output logic              success,
    output logic [DATA_W-1:0] restore_val
);
    localparam logic [ADDR_W-1:0] FULL_ADDR = ADDR_W'(NUM_SLOTS);
    localparam logic [DATA_W-1:0] TOL_HI_WORD = DATA_W'({TOL_POSITIVE, TOL_INT});
    localparam logic [DATA_W-1:0] TOL_LO_WORD = DATA_W'(TOL_FRAC);

    logic              accept;
    logic              prog_done;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] slot_rd;
    logic [DATA_W-1:0] slot_last;
    rd_src_e           src;

    assign accept = store_req && !busy && prog_en && (last_addr != FULL_ADDR);

    nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .running (busy),
        .done    (prog_done)
    );

    nvm_slot_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (prog_done),
        .waddr   (last_addr + 1'b1),
        .wdata   (data_q),
        .raddr_a (rd_addr),
        .rdata_a (slot_rd),
        .raddr_b (last_addr),
        .rdata_b (slot_last)
    );

    nvm_restore #(.DATA_W(DATA_W)) u_restore (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (restore_req && !busy),
        .have_slot   (last_addr != '0),
        .slot_val    (slot_last),
        .restore_val (restore_val)
    );

    // Latch store data, advance the address and track the success flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            last_addr <= '0;
            success   <= 1'b0;
        end else begin
            if (store_req && !busy) success <= 1'b0;
            if (accept) data_q <= wiper_in;
            if (prog_done) begin
                last_addr <= last_addr + 1'b1;
                success   <= 1'b1;
            end
        end
    end

    // Decode which source a read address maps to.
    always_comb begin
        if (rd_addr == ADDR_W'(TOL_HI_ADDR))
            src = SRC_TOLH;
        else if (rd_addr == ADDR_W'(TOL_LO_ADDR))
            src = SRC_TOLL;
        else if (rd_addr != '0 && rd_addr <= last_addr)
            src = SRC_SLOT;
        else
            src = SRC_NONE;
    end

    // Register the read result on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_req) begin
            case (src)
                SRC_SLOT: rd_data <= slot_rd;
                SRC_TOLH: rd_data <= TOL_HI_WORD;
                SRC_TOLL: rd_data <= TOL_LO_WORD;
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/nvm_store_seq_chk.sv
// Module: property checker for the store sequencer, bound to the top.
// Assumes single-cycle request pulses and reset held from time zero.
module nvm_store_seq_chk #(
    parameter int unsigned DATA_W      = 10,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned NUM_SLOTS   = 50,
    parameter int unsigned PROG_CYCLES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_en,
    input logic              store_req,
    input logic              restore_req,
    input logic [ADDR_W-1:0] last_addr,
    input logic              busy,
    input logic              success,
    input logic [DATA_W-1:0] restore_val
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);
    localparam int unsigned RUN_W = $clog2(PROG_CYCLES + 2);

    logic [RUN_W-1:0] run_q;

    // Count consecutive busy cycles seen at clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_q <= '0;
        else                 run_q <= run_q + 1'b1;
    end

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !busy && prog_en && last_addr != ADDR_W'(NUM_SLOTS)) |=> busy);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(PROG_CYCLES)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_addr != $past(last_addr)) |-> (last_addr == $past(last_addr) + 1'b1 && $fell(busy)));

    // R4
    success_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(success) |-> $fell(busy));

    // R5
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !busy && !prog_en) |=> (!busy && !success && $stable(last_addr)));

    // R6
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !busy && last_addr == ADDR_W'(NUM_SLOTS)) |=> (!busy && !success));

    // R10
    restore_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !busy) |=> (restore_val == MID));
endmodule

bind nvm_store_seq nvm_store_seq_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_en     (prog_en),
    .store_req   (store_req),
    .restore_req (restore_req),
    .last_addr   (last_addr),
    .busy        (busy),
    .success     (success),
    .restore_val (restore_val)
);

// File: tb/test_nvm_store_seq.sv
module test_nvm_store_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 10;
    localparam int AW = 6;
    localparam int NS = 50;
    localparam int PC = 8;
    localparam logic [DW-1:0] MID = 10'd512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] wiper_in = '0;
    logic prog_en = 1'b0, store_req = 1'b0, restore_req = 1'b0, rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data, restore_val;
    logic [AW-1:0] last_addr;
    logic busy, success;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0] exp_mem [NS+1];
    int exp_last = 0;
    logic [DW-1:0] exp_restore = MID;

    always #2 clk = ~clk;

    nvm_store_seq #(
        .DATA_W(DW), .ADDR_W(AW), .NUM_SLOTS(NS), .PROG_CYCLES(PC),
        .TOL_POSITIVE(1'b0), .TOL_INT(7'd10), .TOL_FRAC(8'hB0)
    ) i_nvm_store_seq (
        .clk(clk), .rst_n(rst_n), .wiper_in(wiper_in), .prog_en(prog_en),
        .store_req(store_req), .restore_req(restore_req), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .last_addr(last_addr),
        .busy(busy), .success(success), .restore_val(restore_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected read result per R8 and R9.
    function automatic int exp_read(input int a);
        if (a == 'h39) return 'h00A;
        if (a == 'h3A) return 'h0B0;
        if (a >= 1 && a <= exp_last) return int'(exp_mem[a]);
        return 0;
    endfunction

    task automatic do_store(input logic [DW-1:0] d, input logic en);
        bit ok;
        int n;
        ok = en && (exp_last < NS);
        @(negedge clk);
        wiper_in = d; prog_en = en; store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        wiper_in = ~d;
        if (!ok) begin
            chk(en ? "R6 busy" : "R5 busy", int'(busy), 0);
            chk(en ? "R6 success" : "R5 success", int'(success), 0);
            chk(en ? "R6 last_addr" : "R5 last_addr", int'(last_addr), exp_last);
            return;
        end
        chk("R4 success cleared", int'(success), 0);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R2 busy length", n, PC);
        exp_last++;
        exp_mem[exp_last] = d;
        chk("R3 last_addr", int'(last_addr), exp_last);
        chk("R4 success set", int'(success), 1);
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        rd_addr = AW'(a); rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk((a == 'h39 || a == 'h3A) ? "R9 read" : "R8 read", int'(rd_data), exp_read(a));
    endtask

    task automatic do_restore();
        @(negedge clk);
        restore_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0;
        chk("R10 midscale step", int'(restore_val), int'(MID));
        @(negedge clk);
        exp_restore = (exp_last > 0) ? exp_mem[exp_last] : MID;
        chk("R10 stored step", int'(restore_val), int'(exp_restore));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd77));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state (restore pending already resolved, no slots).
        chk("R1 busy", int'(busy), 0);
        chk("R1 success", int'(success), 0);
        chk("R1 last_addr", int'(last_addr), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 restore_val", int'(restore_val), int'(MID));

        // Directed: blank memory reads and restore.
        do_read(0);
        do_read(1);
        do_read('h39);
        do_read('h3A);
        do_restore();
        do_store(10'h155, 1'b0);       // R5
        do_store(10'h100, 1'b1);       // R3 first slot
        do_read(1);
        do_read(2);
        do_restore();

        // R7: requests during busy are ignored.
        @(negedge clk);
        wiper_in = 10'h2AA; prog_en = 1'b1; store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        @(negedge clk);
        store_req = 1'b1; restore_req = 1'b1; wiper_in = 10'h011;
        @(negedge clk);
        store_req = 1'b0; restore_req = 1'b0;
        chk("R7 restore held", int'(restore_val), int'(exp_restore));
        while (busy) @(negedge clk);
        repeat (PC + 2) @(negedge clk);
        exp_last++;
        exp_mem[exp_last] = 10'h2AA;
        chk("R7 last_addr", int'(last_addr), exp_last);
        chk("R7 busy", int'(busy), 0);
        do_read(exp_last);

        // Random mix of stores, reads and restores.
        for (int i = 0; i < 60; i++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0, 1: do_store(DW'($urandom), ($urandom % 5) != 0);
                2: do_read(int'($urandom % 64));
                default: do_restore();
            endcase
        end

        // Fill to full, then refuse (R6).
        while (exp_last < NS) do_store(DW'($urandom), 1'b1);
        chk("R3 final address", int'(last_addr), NS);
        do_store(10'h3FF, 1'b1);
        do_read(NS);
        do_read(NS + 1);
        do_read('h39);
        do_restore();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule